// File: doc/BRIEF.md
# System Exception Pending/Active State Unit

This unit keeps the pending and active flags for the fixed system exceptions of a small processor core (non-maskable interrupt, memory-management fault, bus fault, usage fault, supervisor call, debug monitor, deferred service request and the periodic tick). It keeps the same flags for a parameterised set of external interrupt lines, which take exception numbers from 16 upward. Software reaches the state through a 32-bit register port. The port offers an interrupt-control/state word, a system-handler control/status word, a software-trigger register, a controller-type word and a vector-table base register.

Hardware sources raise pending flags through one-cycle pulse inputs. The exception-entry logic of the core reports each accepted vector on an acknowledge strobe, which moves the flag from pending to active. It reports each finished handler on a completion strobe. The unit outputs the lowest-numbered eligible pending exception. Priority arbitration between levels is done outside the unit.

Top module: `exc_state_unit`

## Requirements
- R1: After a synchronous active-low reset, all pending and active flags, the three fault enables and the vector-table base are zero, and `pend_valid_o` is 0.
- R2: A register write to offset 0xD04 with data bit 31 set pends exception 2. Data bit 28 set pends exception 14, and data bit 26 set pends exception 15.
- R3: In that write, bit 27 clears the pending flag of exception 14 and bit 25 clears the pending flag of exception 15. Each clear has no effect when its set bit (28 or 26) is also 1 in the same word.
- R4: A read of 0xD04 returns `act_vec_i` in bits 8:0 and the pending vector in bits 20:12 (zero when none). Bit 11 is 1 when at most one exception is active. Bit 22 is 1 when any external line is pending. Bits 26, 28 and 31 show the pending flags of exceptions 15, 14 and 2.
- R5: A read of 0xD24 returns the active flags in bits 0 (exc 4), 1 (exc 5), 3 (exc 6), 7 (exc 11), 8 (exc 12), 10 (exc 14) and 11 (exc 15). It returns the pending flags in bits 12 (exc 6), 13 (exc 4), 14 (exc 5) and 15 (exc 11), and the fault enables in bits 16 (exc 4), 17 (exc 5) and 18 (exc 6).
- R6: A write to 0xD24 changes only the three fault enables in bits 18:16. All other written bits are ignored.
- R7: A write to 0xF00 pends exception 16+n, where n is data bits 8:0. The write is ignored when n is not below `NUM_EXT`, and data bits above 8 are ignored.
- R8: A read of 0x004 returns `NUM_EXT`/32 − 1.
- R9: A write to 0xD08 stores the data with bits 6:0 forced to zero, and a read of 0xD08 returns the stored value.
- R10: `pend_vec_o` is the lowest-numbered pending exception that is eligible, or 0 when none is. Exceptions 4, 5 and 6 are eligible only while their enable is set, and all others always. `pend_valid_o` is 1 exactly when an eligible exception is pending.
- R11: A pulse on `sys_pend_i[k]` (k an implemented system exception number) or on `ext_pend_i[n]` (exception 16+n) sets the pending flag at the next clock edge.
- R12: `ack_i` with `ack_vec_i` moves that exception from pending to active. A pend of the same exception in the same cycle leaves it pending. `done_i` with `done_vec_i` clears its active flag, and an acknowledge of the same exception in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset (read and write) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| sys_pend_i | input | 16 | Hardware pend pulses, indexed by system exception number |
| ext_pend_i | input | NUM_EXT | Hardware pend pulses for external lines |
| ack_i | input | 1 | Exception accepted by the core |
| ack_vec_i | input | VW | Exception number accepted |
| done_i | input | 1 | Handler completed |
| done_vec_i | input | VW | Exception number completed |
| act_vec_i | input | VW | Currently running exception number, 0 when none |
| pend_valid_o | output | 1 | An eligible exception is pending |
| pend_vec_o | output | VW | Lowest eligible pending exception number |

## Verification
The bench writes the set and clear bit of one flag together. A design that lets the clear win would lose the pend. It also issues an acknowledge together with a new pend, and a completion together with an acknowledge, on one exception. Getting either order wrong drops a pending flag or an active flag, and this shows up in the status words. A software trigger at and above the line count is tried: an unguarded index would pend a vector that does not exist, or alias line 0. The fault enables are toggled while faults are pending, which shows whether disabled faults are wrongly picked as the pending vector. The bench counts the active flags for the return-to-base bit, which catches an off-by-one in the comparison.

// File: rtl/exc_state_pkg.sv
`timescale 1ns/1ps
// Package: exception numbers, register offsets and the implemented-exception
// mask shared by the state unit and its submodules.
package exc_state_pkg;
    localparam int EXC_NMI     = 2;
    localparam int EXC_MEMF    = 4;
    localparam int EXC_BUSF    = 5;
    localparam int EXC_USEF    = 6;
    localparam int EXC_SVC     = 11;
    localparam int EXC_DBG     = 12;
    localparam int EXC_DEFER   = 14;
    localparam int EXC_TICK    = 15;
    localparam int EXT_BASE    = 16;

    // Bit k set when system exception k exists.
    localparam logic [15:0] SYS_IMPL = 16'hD874;

    localparam logic [11:0] OFF_CTYPE = 12'h004;
    localparam logic [11:0] OFF_CTRL  = 12'hD04;
    localparam logic [11:0] OFF_VBASE = 12'hD08;
    localparam logic [11:0] OFF_HSTAT = 12'hD24;
    localparam logic [11:0] OFF_TRIG  = 12'hF00;
endpackage

// File: rtl/exc_state_bank.sv
`timescale 1ns/1ps
// Module: exc_state_bank
// Holds one pending and one active flag per exception number. Set wins
// over clear and acknowledge for pending; acknowledge wins over completion
// for active. Unimplemented system numbers are tied to zero.
// Assumes the hit vectors are one-cycle strobes decoded by the parent.
module exc_state_bank #(
    parameter int NV = 80,
    parameter logic [15:0] IMPL = 16'hFFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NV-1:0] set_hit,
    input  logic [NV-1:0] clr_hit,
    input  logic [NV-1:0] ack_hit,
    input  logic [NV-1:0] done_hit,
    output logic [NV-1:0] pend_q,
    output logic [NV-1:0] act_q
);
    for (genvar v = 0; v < NV; v++) begin : g_bit
        if (v < 16 && !IMPL[v]) begin : g_none
            assign pend_q[v] = 1'b0;
            assign act_q[v]  = 1'b0;
        end else begin : g_flag
            logic p_r, a_r;
            // Pending flag: set dominates clear and acknowledge.
            always_ff @(posedge clk) begin
                if (!rst_n) p_r <= 1'b0;
                else        p_r <= (p_r & ~clr_hit[v] & ~ack_hit[v]) | set_hit[v];
            end
            // Active flag: acknowledge dominates completion.
            always_ff @(posedge clk) begin
                if (!rst_n) a_r <= 1'b0;
                else        a_r <= (a_r & ~done_hit[v]) | ack_hit[v];
            end
            assign pend_q[v] = p_r;
            assign act_q[v]  = a_r;

            p_set_pends_r11: assert property (@(posedge clk) disable iff (!rst_n)
                set_hit[v] |=> pend_q[v]);
            p_ack_to_active_r12: assert property (@(posedge clk) disable iff (!rst_n)
                ack_hit[v] |=> act_q[v]);
            p_ack_leaves_pend_r12: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_hit[v] && !set_hit[v]) |=> !pend_q[v]);
            p_done_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
                (done_hit[v] && !ack_hit[v]) |=> !act_q[v]);
        end
    end
endmodule

// File: rtl/exc_lowest_pick.sv
`timescale 1ns/1ps
// Module: exc_lowest_pick
// Finds the lowest set bit of the eligibility vector and reports its index.
// Assumes NV <= 2**VW. Purely combinational.
module exc_lowest_pick #(
    parameter int NV = 80,
    parameter int VW = 7
) (
    input  logic [NV-1:0] elig,
    output logic          valid,
    output logic [VW-1:0] vec
);
    // Scan from the top so that the lowest hit is written last.
    always_comb begin
        valid = 1'b0;
        vec   = '0;
        for (int v = NV - 1; v >= 0; v--) begin
            if (elig[v]) begin
                valid = 1'b1;
                vec   = VW'(v);
            end
        end
    end
endmodule

// File: rtl/exc_state_unit.sv
`timescale 1ns/1ps
// Module: exc_state_unit
// Register front end for the system-exception and external-interrupt
// pending/active state. Decodes the register port into per-vector set and
// clear strobes, keeps the fault enables and vector-table base, and builds
// the status words. Assumes NUM_EXT is a multiple of 32 and at most 496.
module exc_state_unit
    import exc_state_pkg::*;
#(
    parameter int NUM_EXT = 64,
    parameter int NV      = EXT_BASE + NUM_EXT,
    parameter int VW      = $clog2(NV)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_i,
    input  logic [11:0]        reg_addr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    input  logic [15:0]        sys_pend_i,
    input  logic [NUM_EXT-1:0] ext_pend_i,
    input  logic               ack_i,
    input  logic [VW-1:0]      ack_vec_i,
    input  logic               done_i,
    input  logic [VW-1:0]      done_vec_i,
    input  logic [VW-1:0]      act_vec_i,
    output logic               pend_valid_o,
    output logic [VW-1:0]      pend_vec_o
);
    localparam logic [31:0] CTYPE_VAL = 32'(NUM_EXT / 32 - 1);

    logic          wr_ctrl, wr_hstat, wr_trig, wr_vbase;
    logic [NV-1:0] set_hit, clr_hit, ack_hit, done_hit;
    logic [NV-1:0] pend_q, act_q, elig;
    logic [2:0]    fault_en_q;   // {usage, bus, mem}
    logic [31:7]   vbase_q;
    logic          ret_base, any_ext;
    logic [31:0]   rd_ctrl, rd_hstat;

    assign wr_ctrl  = reg_wr_i && (reg_addr_i == OFF_CTRL);
    assign wr_hstat = reg_wr_i && (reg_addr_i == OFF_HSTAT);
    assign wr_trig  = reg_wr_i && (reg_addr_i == OFF_TRIG);
    assign wr_vbase = reg_wr_i && (reg_addr_i == OFF_VBASE);

    // Per-vector set/clear strobes from software, hardware pulses and the core.
    always_comb begin
        set_hit  = '0;
        clr_hit  = '0;
        ack_hit  = '0;
        done_hit = '0;
        set_hit[15:0] = sys_pend_i & SYS_IMPL;
        set_hit[NV-1:EXT_BASE] = ext_pend_i;
        if (wr_ctrl) begin
            set_hit[EXC_NMI]   = set_hit[EXC_NMI]   | reg_wdata_i[31];
            set_hit[EXC_DEFER] = set_hit[EXC_DEFER] | reg_wdata_i[28];
            set_hit[EXC_TICK]  = set_hit[EXC_TICK]  | reg_wdata_i[26];
            clr_hit[EXC_DEFER] = reg_wdata_i[27] & ~reg_wdata_i[28];
            clr_hit[EXC_TICK]  = reg_wdata_i[25] & ~reg_wdata_i[26];
        end
        for (int n = 0; n < NUM_EXT; n++) begin
            if (wr_trig && reg_wdata_i[8:0] == 9'(n))
                set_hit[EXT_BASE + n] = 1'b1;
        end
        for (int v = 0; v < NV; v++) begin
            ack_hit[v]  = ack_i  && (ack_vec_i  == VW'(v));
            done_hit[v] = done_i && (done_vec_i == VW'(v));
        end
    end

    exc_state_bank #(.NV(NV), .IMPL(SYS_IMPL)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_hit  (set_hit),
        .clr_hit  (clr_hit),
        .ack_hit  (ack_hit),
        .done_hit (done_hit),
        .pend_q   (pend_q),
        .act_q    (act_q)
    );

    // Fault enables: only bits 18:16 of the handler word are writable.
    always_ff @(posedge clk) begin
        if (!rst_n)        fault_en_q <= 3'b000;
        else if (wr_hstat) fault_en_q <= reg_wdata_i[18:16];
    end

    // Vector-table base, aligned to 128 bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)        vbase_q <= '0;
        else if (wr_vbase) vbase_q <= reg_wdata_i[31:7];
    end

    // Eligibility: faults gated by their enables, all others always eligible.
    always_comb begin
        elig = pend_q;
        elig[EXC_MEMF] = pend_q[EXC_MEMF] & fault_en_q[0];
        elig[EXC_BUSF] = pend_q[EXC_BUSF] & fault_en_q[1];
        elig[EXC_USEF] = pend_q[EXC_USEF] & fault_en_q[2];
    end

    exc_lowest_pick #(.NV(NV), .VW(VW)) pick_i (
        .elig  (elig),
        .valid (pend_valid_o),
        .vec   (pend_vec_o)
    );

    // Return-to-base: at most one exception active.
    always_comb begin
        int cnt;
        cnt = 0;
        for (int v = 0; v < NV; v++) cnt = cnt + int'(act_q[v]);
        ret_base = (cnt <= 1);
    end

    assign any_ext = |pend_q[NV-1:EXT_BASE];

    // Interrupt control/state word.
    always_comb begin
        rd_ctrl = '0;
        rd_ctrl[VW-1:0]  = act_vec_i;
        rd_ctrl[11]      = ret_base;
        rd_ctrl[12 +: VW] = pend_vec_o;
        rd_ctrl[22]      = any_ext;
        rd_ctrl[26]      = pend_q[EXC_TICK];
        rd_ctrl[28]      = pend_q[EXC_DEFER];
        rd_ctrl[31]      = pend_q[EXC_NMI];
    end

    // System handler control/status word.
    always_comb begin
        rd_hstat = '0;
        rd_hstat[0]  = act_q[EXC_MEMF];
        rd_hstat[1]  = act_q[EXC_BUSF];
        rd_hstat[3]  = act_q[EXC_USEF];
        rd_hstat[7]  = act_q[EXC_SVC];
        rd_hstat[8]  = act_q[EXC_DBG];
        rd_hstat[10] = act_q[EXC_DEFER];
        rd_hstat[11] = act_q[EXC_TICK];
        rd_hstat[12] = pend_q[EXC_USEF];
        rd_hstat[13] = pend_q[EXC_MEMF];
        rd_hstat[14] = pend_q[EXC_BUSF];
        rd_hstat[15] = pend_q[EXC_SVC];
        rd_hstat[18:16] = fault_en_q;
    end

    // Read multiplexer; unknown offsets read zero.
    always_comb begin
        case (reg_addr_i)
            OFF_CTYPE: reg_rdata_o = CTYPE_VAL;
            OFF_CTRL:  reg_rdata_o = rd_ctrl;
            OFF_VBASE: reg_rdata_o = {vbase_q, 7'b0};
            OFF_HSTAT: reg_rdata_o = rd_hstat;
            default:   reg_rdata_o = '0;
        endcase
    end

    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata_i[28]) |=> pend_q[EXC_DEFER]);
    p_tick_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata_i[26]) |=> pend_q[EXC_TICK]);
    p_pick_eligible_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid_o |-> elig[pend_vec_o]);
    p_pick_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid_o |-> (elig == '0 && pend_vec_o == '0));
    p_enable_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hstat |=> (fault_en_q == $past(reg_wdata_i[18:16])));
endmodule

// File: tb/exc_state_unit_tb_top.sv
`timescale 1ns/1ps
// Directed bench for exc_state_unit: one task per scenario.
module exc_state_unit_tb_top;
    localparam int NUM_EXT = 64;
    localparam int VW = 7;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               reg_wr_i;
    logic [11:0]        reg_addr_i;
    logic [31:0]        reg_wdata_i;
    logic [31:0]        reg_rdata_o;
    logic [15:0]        sys_pend_i;
    logic [NUM_EXT-1:0] ext_pend_i;
    logic               ack_i, done_i;
    logic [VW-1:0]      ack_vec_i, done_vec_i, act_vec_i;
    logic               pend_valid_o;
    logic [VW-1:0]      pend_vec_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    exc_state_unit #(.NUM_EXT(NUM_EXT)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .sys_pend_i(sys_pend_i), .ext_pend_i(ext_pend_i),
        .ack_i(ack_i), .ack_vec_i(ack_vec_i), .done_i(done_i),
        .done_vec_i(done_vec_i), .act_vec_i(act_vec_i),
        .pend_valid_o(pend_valid_o), .pend_vec_o(pend_vec_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Write one register; state is visible at the following negedge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1 d = reg_rdata_o;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic ack(input int v);
        ack_i = 1'b1; ack_vec_i = VW'(v);
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic done(input int v);
        done_i = 1'b1; done_vec_i = VW'(v);
        @(negedge clk);
        done_i = 1'b0;
    endtask

    task automatic pulse_sys(input logic [15:0] m);
        sys_pend_i = m;
        @(negedge clk);
        sys_pend_i = '0;
    endtask

    task automatic t_reset();
        check("R1 pend_valid", 32'(pend_valid_o), 0);
        rd_chk("R1 R4 ctrl word", 12'hD04, 32'h0000_0800);
        rd_chk("R1 handler word", 12'hD24, 32'h0);
        rd_chk("R1 vbase", 12'hD08, 32'h0);
        rd_chk("R8 ctype", 12'h004, 32'h1);
        rd_chk("R4 unknown offset", 12'h100, 32'h0);
    endtask

    task automatic t_ctrl_word();
        wr(12'hD04, 32'h9400_0000);
        rd_chk("R2 R4 set nmi/defer/tick", 12'hD04, 32'h9400_2800);
        check("R10 vec nmi", 32'(pend_vec_o), 2);
        wr(12'hD04, 32'h0A00_0000);
        rd_chk("R3 clears", 12'hD04, 32'h8000_2800);
        wr(12'hD04, 32'h1800_0000);
        rd_chk("R3 set wins 14", 12'hD04, 32'h9000_2800);
        wr(12'hD04, 32'h0600_0000);
        rd_chk("R3 set wins 15", 12'hD04, 32'h9400_2800);
        act_vec_i = 7'd2; ack(2);
        rd_chk("R12 R4 ack nmi", 12'hD04, 32'h1400_E802);
        act_vec_i = 7'd14; ack(14);
        rd_chk("R4 two active", 12'hD04, 32'h0400_F00E);
        rd_chk("R5 defer active", 12'hD24, 32'h0000_0400);
        done(14); done(2);
        act_vec_i = 7'd15; ack(15);
        rd_chk("R5 tick active", 12'hD24, 32'h0000_0800);
        done(15); act_vec_i = '0;
        rd_chk("R12 all done", 12'hD04, 32'h0000_0800);
    endtask

    task automatic t_handler_word();
        wr(12'hD24, 32'hFFFF_FFFF);
        rd_chk("R6 only enables", 12'hD24, 32'h0007_0000);
        pulse_sys(16'h0870);
        rd_chk("R11 R5 fault pends", 12'hD24, 32'h0007_F000);
        check("R10 lowest fault", 32'(pend_vec_o), 4);
        wr(12'hD24, 32'h0);
        rd_chk("R6 disable", 12'hD24, 32'h0000_F000);
        check("R10 disabled skipped", 32'(pend_vec_o), 11);
        ack(11);
        rd_chk("R5 svc active", 12'hD24, 32'h0000_7080);
        check("R10 none eligible valid", 32'(pend_valid_o), 0);
        check("R10 none eligible vec", 32'(pend_vec_o), 0);
        wr(12'hD24, 32'h0007_0000);
        check("R10 re-enabled", 32'(pend_vec_o), 4);
        ack(4); ack(5); ack(6);
        rd_chk("R5 fault actives", 12'hD24, 32'h0007_008B);
        done(4); done(5); done(6); done(11);
        rd_chk("R12 faults done", 12'hD24, 32'h0007_0000);
        pulse_sys(16'h1000); ack(12);
        rd_chk("R5 debug active", 12'hD24, 32'h0007_0100);
        done(12);
    endtask

    task automatic t_trigger();
        wr(12'hF00, 32'd64);
        check("R7 out of range ignored", 32'(pend_valid_o), 0);
        wr(12'hF00, 32'h1FF);
        rd_chk("R7 max ignored", 12'hD04, 32'h0000_0800);
        wr(12'hF00, 32'h203);
        check("R7 high bits ignored", 32'(pend_vec_o), 19);
        rd_chk("R4 ext pending word", 12'hD04, 32'h0041_3800);
        wr(12'hF00, 32'd63);
        check("R10 lowest of two", 32'(pend_vec_o), 19);
        ack(19);
        check("R7 top line", 32'(pend_vec_o), 79);
        ack(79); done(19); done(79);
        check("R12 ext cleared", 32'(pend_valid_o), 0);
    endtask

    task automatic t_hw_and_races();
        ext_pend_i[10] = 1'b1; @(negedge clk); ext_pend_i = '0;
        check("R11 ext pulse", 32'(pend_vec_o), 26);
        ext_pend_i[10] = 1'b1; ack_i = 1'b1; ack_vec_i = 7'd26;
        @(negedge clk);
        ext_pend_i = '0; ack_i = 1'b0;
        check("R12 pend beats ack", 32'(pend_valid_o), 1);
        ack(26);
        check("R12 second ack", 32'(pend_valid_o), 0);
        done(26);
        pulse_sys(16'h0800); ack(11); pulse_sys(16'h0800);
        ack_i = 1'b1; ack_vec_i = 7'd11; done_i = 1'b1; done_vec_i = 7'd11;
        @(negedge clk);
        ack_i = 1'b0; done_i = 1'b0;
        rd_chk("R12 ack beats done", 12'hD24, 32'h0007_0080);
        done(11);
        rd_chk("R12 done clears", 12'hD24, 32'h0007_0000);
        pulse_sys(16'h8004);
        rd_chk("R11 nmi tick pulses", 12'hD04, 32'h8400_2800);
        ack(2); ack(15); done(2); done(15);
    endtask

    task automatic t_vbase();
        wr(12'hD08, 32'h2000_00FF);
        rd_chk("R9 aligned", 12'hD08, 32'h2000_0080);
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
        sys_pend_i = '0; ext_pend_i = '0; ack_i = 1'b0; done_i = 1'b0;
        ack_vec_i = '0; done_vec_i = '0; act_vec_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_word();
        t_handler_word();
        t_trigger();
        t_hw_and_races();
        t_vbase();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule